// File: doc/BRIEF.md
# Comparator-Gated Set/Reset Latch Controller

This block holds one bit of latch state. The latch is set and cleared by two digital comparator results and by software pulse requests. One 8-bit control register, reached over a simple select/write-enable bus, sets all of its behaviour. Each comparator result passes through a synchronizer before it is used. A separate enable gates each comparator's path into the latch: comparator 1 can only set the latch and comparator 2 can only reset it. Software sets or clears the latch by writing a one to a self-clearing pulse bit.

Each of the two comparator pins is routed on its own, either to the synchronized raw comparator result or to the latch output. Drive is granted only when the pin's output-enable and its output-direction inputs are both high. The software status outputs always carry the synchronized comparator results, never the latch. A reference-enable bit is stored and exported unchanged.

Top module: `cmp_latch_ctl`

## Requirements
- R1: After reset, `bus_rdata` reads 0x00, `ref_en` is 0, the latch is 0, and both pin drive outputs are 0 while their enables are low.
- R2: Control register bits are: bit 7 pin-2 source select, bit 6 pin-1 source select, bit 5 comparator-1 set enable, bit 4 comparator-2 reset enable, bit 3 software set pulse, bit 2 software reset pulse, bit 1 unused, bit 0 reference enable. Bits 7..4 and 0 read back as written. Bits 3..1 always read 0. `ref_en` equals bit 0.
- R3: With bit 5 at 1, a high `cmp1_in` sets the latch three clock edges after the input changes. With bit 5 at 0, `cmp1_in` has no effect on the latch.
- R4: With bit 4 at 1, a high `cmp2_in` clears the latch three clock edges after the input changes. With bit 4 at 0, `cmp2_in` has no effect on the latch.
- R5: Writing 1 to bit 3 (or bit 2) sets (or clears) the latch two edges after the write edge. The bit reads 0 right after the write. Writing 0 to these bits leaves the latch unchanged.
- R6: When a set and a reset request are active in the same cycle, the latch is cleared.
- R7: A select bit of 1 puts the latch output on that pin's `pinN_out`. A select bit of 0 puts the synchronized comparator N result there, two edges after the input changes.
- R8: `cmp_status[0]` and `cmp_status[1]` show the synchronized comparator 1 and 2 results, two edges after the inputs change, whatever the latch state and the select bits.
- R9: `pinN_drive` is high exactly when `pinN_oe` and `pinN_dir_out` are both high.
- R10: The register changes only on a clock edge where `bus_sel` and `bus_we` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register selected |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value |
| cmp1_in | input | 1 | Comparator 1 result (asynchronous) |
| cmp2_in | input | 1 | Comparator 2 result (asynchronous) |
| pin1_oe | input | 1 | Pin 1 output enable |
| pin1_dir_out | input | 1 | Pin 1 direction is output |
| pin2_oe | input | 1 | Pin 2 output enable |
| pin2_dir_out | input | 1 | Pin 2 direction is output |
| pin1_out | output | 1 | Pin 1 value |
| pin1_drive | output | 1 | Pin 1 drive enable |
| pin2_out | output | 1 | Pin 2 value |
| pin2_drive | output | 1 | Pin 2 drive enable |
| cmp_status | output | 2 | Synchronized comparator results |
| ref_en | output | 1 | Reference enable |

## Verification
The hard case is a comparator set and reset that meet in the same cycle while the latch already holds a known value. Every start value must be placed, and the comparators held at zero while this happens. The stimulus first forces the start value with a software pulse. It then writes the gate bits and raises both comparators together. This is swept over all 32 combinations of start value, gate bits and comparator levels. The latch is read through pin 1 and the raw comparator 2 through pin 2. A single write with both pulse bits set covers the software form of the collision.

// File: rtl/cmp_latch_pkg.sv
package cmp_latch_pkg;
   localparam int CFG_W = 8;

   typedef struct packed {
      logic sel2;
      logic sel1;
      logic set_en1;
      logic rst_en2;
      logic sw_set;
      logic sw_rst;
      logic spare;
      logic ref_on;
   } cfg_t;
endpackage

// File: rtl/cmp_latch_sync.sv
module cmp_latch_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cmp_latch_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cmp_latch_sync: WIDTH must be at least 1");
   end

   for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[ch]};
      end
      assign q[ch] = chain[STAGES-1];
   end
endmodule

// File: rtl/cmp_latch_regs.sv
module cmp_latch_regs
   import cmp_latch_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_we,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output cfg_t          cfg,
   output logic          pulse_set,
   output logic          pulse_rst
);
   if (DW != CFG_W) begin : g_bad_dw
      $error("cmp_latch_regs: DW must equal CFG_W");
   end

   cfg_t wr_view;
   logic wr;
   cfg_t held;

   assign wr      = bus_sel & bus_we;
   assign wr_view = cfg_t'(bus_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= '0;
         pulse_set <= 1'b0;
         pulse_rst <= 1'b0;
      end else begin
         pulse_set <= wr & wr_view.sw_set;
         pulse_rst <= wr & wr_view.sw_rst;
         if (wr) begin
            held.sel2    <= wr_view.sel2;
            held.sel1    <= wr_view.sel1;
            held.set_en1 <= wr_view.set_en1;
            held.rst_en2 <= wr_view.rst_en2;
            held.ref_on  <= wr_view.ref_on;
         end
         held.sw_set <= 1'b0;
         held.sw_rst <= 1'b0;
         held.spare  <= 1'b0;
      end
   end

   assign cfg       = held;
   assign bus_rdata = DW'(held);

   AST_PULSE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_set && !(wr && wr_view.sw_set)) |=> !pulse_set); // R5
   AST_PULSE_R_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_rst && !(wr && wr_view.sw_rst)) |=> !pulse_rst); // R5
   AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(bus_rdata)); // R10
endmodule

// File: rtl/cmp_latch_core.sv
module cmp_latch_core (
   input  logic clk,
   input  logic rst_n,
   input  logic c1,
   input  logic c2,
   input  logic set_en1,
   input  logic rst_en2,
   input  logic pulse_set,
   input  logic pulse_rst,
   output logic q
);
   logic want_set, want_rst;

   assign want_set = (set_en1 & c1) | pulse_set;
   assign want_rst = (rst_en2 & c2) | pulse_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (want_rst) q <= 1'b0;
      else if (want_set) q <= 1'b1;
   end

   AST_RESET_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
      want_rst |=> !q); // R6
   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (want_set && !want_rst) |=> q); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!want_set && !want_rst) |=> $stable(q)); // R4
endmodule

// File: rtl/cmp_latch_ctl.sv
module cmp_latch_ctl
   import cmp_latch_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_we,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       cmp1_in,
   input  logic       cmp2_in,
   input  logic       pin1_oe,
   input  logic       pin1_dir_out,
   input  logic       pin2_oe,
   input  logic       pin2_dir_out,
   output logic       pin1_out,
   output logic       pin1_drive,
   output logic       pin2_out,
   output logic       pin2_drive,
   output logic [1:0] cmp_status,
   output logic       ref_en
);
   localparam int NPINS = 2;

   cfg_t             cfg;
   logic             pulse_set, pulse_rst;
   logic [NPINS-1:0] cmp_sync;
   logic             latch_q;
   logic [NPINS-1:0] sel_v, oe_v, dir_v, out_v, drv_v;

   cmp_latch_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cmp2_in, cmp1_in}), .q(cmp_sync));

   cmp_latch_regs #(.DW(CFG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg(cfg),
      .pulse_set(pulse_set), .pulse_rst(pulse_rst));

   cmp_latch_core u_core (
      .clk(clk), .rst_n(rst_n), .c1(cmp_sync[0]), .c2(cmp_sync[1]),
      .set_en1(cfg.set_en1), .rst_en2(cfg.rst_en2),
      .pulse_set(pulse_set), .pulse_rst(pulse_rst), .q(latch_q));

   assign sel_v = {cfg.sel2, cfg.sel1};
   assign oe_v  = {pin2_oe, pin1_oe};
   assign dir_v = {pin2_dir_out, pin1_dir_out};

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign out_v[p] = sel_v[p] ? latch_q : cmp_sync[p];
      assign drv_v[p] = oe_v[p] & dir_v[p];
   end

   assign pin1_out   = out_v[0];
   assign pin2_out   = out_v[1];
   assign pin1_drive = drv_v[0];
   assign pin2_drive = drv_v[1];
   assign cmp_status = cmp_sync;
   assign ref_en     = cfg.ref_on;

   AST_REF_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we) |=> (ref_en == $past(bus_wdata[0]))); // R2
endmodule

// File: tb/cmp_latch_ctl_test.sv
`timescale 1ns/1ps
module cmp_latch_ctl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       cmp1_in = 1'b0, cmp2_in = 1'b0;
   logic       pin1_oe = 1'b0, pin1_dir_out = 1'b0, pin2_oe = 1'b0, pin2_dir_out = 1'b0;
   logic       pin1_out, pin1_drive, pin2_out, pin2_drive, ref_en;
   logic [1:0] cmp_status;
   int         checks = 0, fails = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   cmp_latch_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cmp1_in(cmp1_in), .cmp2_in(cmp2_in),
      .pin1_oe(pin1_oe), .pin1_dir_out(pin1_dir_out),
      .pin2_oe(pin2_oe), .pin2_dir_out(pin2_dir_out),
      .pin1_out(pin1_out), .pin1_drive(pin1_drive),
      .pin2_out(pin2_out), .pin2_drive(pin2_drive),
      .cmp_status(cmp_status), .ref_en(ref_en));

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_cycle(logic s, logic w, logic [7:0] d);
      bus_sel = s; bus_we = w; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
   endtask

   task automatic wr(logic [7:0] d);
      bus_cycle(1'b1, 1'b1, d);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 rdata", bus_rdata, 8'h00);
      check("R1 ref_en", {7'b0, ref_en}, 8'h00);
      check("R1 drive", {6'b0, pin2_drive, pin1_drive}, 8'h00);
      wr(8'h40);
      check("R1 latch", {7'b0, pin1_out}, 8'h00);

      // R2 layout and readback
      wr(8'hFF);
      check("R2 readback FF", bus_rdata, 8'hF1);
      check("R2 ref_en on", {7'b0, ref_en}, 8'h01);
      wr(8'hA0);
      check("R2 readback A0", bus_rdata, 8'hA0);
      check("R2 ref_en off", {7'b0, ref_en}, 8'h00);
      wr(8'h51);
      check("R2 readback 51", bus_rdata, 8'h51);

      // R10 writes without both strobes are ignored
      bus_cycle(1'b1, 1'b0, 8'h08);
      check("R10 we low", bus_rdata, 8'h51);
      bus_cycle(1'b0, 1'b1, 8'hA8);
      check("R10 sel low", bus_rdata, 8'h51);
      idle(1);
      check("R10 no pulse", {7'b0, pin1_out}, 8'h00);

      // R5 pulses, readback zero, write of zero does nothing
      wr(8'h48);
      check("R5 pulse bit reads 0", bus_rdata, 8'h40);
      idle(1);
      check("R5 set pulse", {7'b0, pin1_out}, 8'h01);
      wr(8'h40);
      idle(2);
      check("R5 zero write holds", {7'b0, pin1_out}, 8'h01);
      wr(8'h44);
      check("R5 reset bit reads 0", bus_rdata, 8'h40);
      idle(1);
      check("R5 reset pulse", {7'b0, pin1_out}, 8'h00);
      wr(8'h48); idle(1);
      // R6 software collision: both pulse bits
      wr(8'h4C); idle(1);
      check("R6 both pulses clear", {7'b0, pin1_out}, 8'h00);

      // R3 R4 R6 R7 exhaustive comparator sweep
      for (int k = 0; k < 32; k++) begin
         logic q0, sen, ren, c1, c2, expq;
         q0 = k[4]; sen = k[3]; ren = k[2]; c1 = k[1]; c2 = k[0];
         wr(q0 ? 8'h48 : 8'h44);
         idle(1);
         wr({2'b01, sen, ren, 4'b0000});
         cmp1_in = c1; cmp2_in = c2;
         idle(3);
         expq = (ren & c2) ? 1'b0 : ((sen & c1) ? 1'b1 : q0);
         if (ren & c2) check("R6 R4 reset path", {7'b0, pin1_out}, {7'b0, expq});
         else if (sen & c1) check("R3 set path", {7'b0, pin1_out}, {7'b0, expq});
         else check("R3 R4 gated hold", {7'b0, pin1_out}, {7'b0, expq});
         check("R7 pin2 raw", {7'b0, pin2_out}, {7'b0, c2});
         check("R8 status", {6'b0, cmp_status}, {6'b0, c2, c1});
         cmp1_in = 1'b0; cmp2_in = 1'b0;
         idle(3);
      end

      // R7 R8 latency and select independence
      wr(8'h08); idle(1);
      wr(8'h00);
      cmp1_in = 1'b0; cmp2_in = 1'b1;
      idle(1);
      check("R8 one edge not yet", {6'b0, cmp_status}, 8'h00);
      idle(1);
      check("R8 two edges", {6'b0, cmp_status}, 8'h02);
      check("R7 pin1 raw", {7'b0, pin1_out}, 8'h00);
      check("R7 pin2 raw high", {7'b0, pin2_out}, 8'h01);
      wr(8'hC0);
      check("R7 pin1 latch", {7'b0, pin1_out}, 8'h01);
      check("R7 pin2 latch", {7'b0, pin2_out}, 8'h01);
      check("R8 status ignores latch", {6'b0, cmp_status}, 8'h02);
      cmp2_in = 1'b0; idle(3);

      // R9 drive sweep
      for (int m = 0; m < 16; m++) begin
         pin1_oe = m[0]; pin1_dir_out = m[1]; pin2_oe = m[2]; pin2_dir_out = m[3];
         #1;
         check("R9 drive", {6'b0, pin2_drive, pin1_drive},
               {6'b0, m[2] & m[3], m[0] & m[1]});
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule